// File: doc/BRIEF.md
# Single-Precision NaN Classifier and Quieter

This block inspects one 32-bit single-precision floating-point operand and tells whether it is a NaN, and if so whether that NaN is a signalling one. When the operand is a signalling NaN, the block produces the matching quiet NaN and raises an invalid-operation flag. Every other operand, including quiet NaNs, infinities, zeros, normals and subnormals, passes through unchanged with no flag. The block sits in front of a floating-point unit's operand path or a conversion stage. The consumer uses the flag to accumulate exception state and uses the result word as the canonical operand.

A single mode input picks the meaning of the top fraction bit (bit 22). Under the 2008 convention, a set bit 22 marks a quiet NaN. Under the legacy convention, a set bit 22 marks a signalling NaN. In legacy mode, quieting clears bit 22. If that would leave the fraction all zero, which would turn the word into an infinity, the block also sets fraction bit 21 so the word stays a NaN. The decision logic is purely combinational. A parameter places an output register after it, and that register is present by default.

Top module: `nan_quiet_unit`

## Requirements
- R1: `is_nan` is 1 exactly when exponent bits 30:23 are all ones and fraction bits 22:0 are not all zero; an infinity (fraction zero) gives 0.
- R2: `is_snan` is 1 exactly when the operand is a NaN and fraction bit 22 XOR `quiet_is_one` equals 1 (`quiet_is_one`=1 selects the 2008 convention, 0 the legacy convention).
- R3: `invalid` is 1 exactly when the operand is a signalling NaN, under either convention.
- R4: With `quiet_is_one`=1, a signalling NaN is returned with fraction bit 22 set and every other bit (sign, exponent, bits 21:0) unchanged.
- R5: With `quiet_is_one`=0, a signalling NaN is returned with fraction bit 22 cleared. If bits 21:0 are then all zero, bit 21 is set; otherwise bits 21:0 are unchanged. Sign and exponent are kept.
- R6: Any operand that is not a signalling NaN (quiet NaN, infinity, zero, finite value) appears on `result` bit-for-bit unchanged, with `invalid`=0.
- R7: With the default output register, all outputs change one clock edge after the inputs, and a synchronous active-high `rst` drives all outputs to 0.
- R8: A quieted result is always a NaN that reads as quiet under the same convention. Fed back in, it gives `is_nan`=1, `is_snan`=0 and `invalid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset, clears outputs |
| op_in | input | 32 | Operand: sign bit 31, exponent 30:23, fraction 22:0 |
| quiet_is_one | input | 1 | 1: set bit 22 means quiet (2008); 0: set bit 22 means signalling (legacy) |
| is_nan | output | 1 | Operand is a NaN |
| is_snan | output | 1 | Operand is a signalling NaN |
| result | output | 32 | Quieted NaN, or the operand unchanged |
| invalid | output | 1 | Invalid-operation flag raised by quieting |

## Verification
Because the path is a single register stage, any wrong decision on the classification or quieting path shows up at the ports exactly one edge after the offending operand is applied. A polarity error in the mode handling appears as `is_snan` and `invalid` inverted for every NaN with that bit-22 value. A missing legacy fix-up shows up only on the one fraction pattern with bits 21:0 all zero and bit 22 set. There it yields an infinity rather than a NaN, so the vector set includes that pattern, an all-ones fraction and single-bit fractions at both ends. A quieted word fed back through the block must read as quiet, which catches a quieter and classifier that disagree on bit polarity.

// File: rtl/nan_fp_pkg.sv
package nan_fp_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int QBIT   = FRAC_W - 1;
    localparam int FIXBIT = FRAC_W - 2;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef enum logic {
        CONV_LEGACY = 1'b0,
        CONV_2008   = 1'b1
    } nan_conv_e;

    typedef struct packed {
        logic nan;
        logic snan;
    } nan_class_t;

    typedef struct packed {
        nan_class_t cls;
        fp_word_t   word;
        logic       invalid;
    } nan_out_t;

    function automatic logic word_is_nan(fp_word_t w);
        return (&w.expo) && (|w.frac);
    endfunction
endpackage

// File: rtl/nan_field_decode.sv
module nan_field_decode
    import nan_fp_pkg::*;
(
    input  fp_word_t   op,
    input  nan_conv_e  conv,
    output nan_class_t cls
);
    always_comb begin
        cls.nan  = word_is_nan(op);
        cls.snan = cls.nan && (op.frac[QBIT] ^ conv);
    end
endmodule

// File: rtl/nan_quieter.sv
module nan_quieter
    import nan_fp_pkg::*;
(
    input  fp_word_t  op,
    input  nan_conv_e conv,
    input  logic      snan,
    output fp_word_t  quieted,
    output logic      invalid
);
    logic [FRAC_W-1:0] legacy_frac;

    always_comb begin
        legacy_frac       = op.frac;
        legacy_frac[QBIT] = 1'b0;
        if (legacy_frac == '0)
            legacy_frac[FIXBIT] = 1'b1;
    end

    always_comb begin
        quieted = op;
        invalid = 1'b0;
        if (snan) begin
            invalid = 1'b1;
            if (conv == CONV_2008)
                quieted.frac[QBIT] = 1'b1;
            else
                quieted.frac = legacy_frac;
        end
    end
endmodule

// File: rtl/nan_out_stage.sv
module nan_out_stage
    import nan_fp_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  nan_out_t d,
    output nan_out_t q
);
    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= d;
            end
        end else begin : g_pass
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/nan_quiet_unit.sv
module nan_quiet_unit
    import nan_fp_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] op_in,
    input  logic              quiet_is_one,
    output logic              is_nan,
    output logic              is_snan,
    output logic [WORD_W-1:0] result,
    output logic              invalid
);
    fp_word_t   op_w;
    nan_conv_e  conv;
    nan_class_t cls_c;
    fp_word_t   q_word;
    logic       inv_c;
    nan_out_t   stage_d;
    nan_out_t   stage_q;

    assign op_w = fp_word_t'(op_in);
    assign conv = nan_conv_e'(quiet_is_one);

    nan_field_decode u_decode (
        .op   (op_w),
        .conv (conv),
        .cls  (cls_c)
    );

    nan_quieter u_quiet (
        .op      (op_w),
        .conv    (conv),
        .snan    (cls_c.snan),
        .quieted (q_word),
        .invalid (inv_c)
    );

    always_comb begin
        stage_d.cls     = cls_c;
        stage_d.word    = q_word;
        stage_d.invalid = inv_c;
    end

    nan_out_stage #(.REG_OUT(REG_OUT)) u_stage (
        .clk (clk),
        .rst (rst),
        .d   (stage_d),
        .q   (stage_q)
    );

    assign is_nan  = stage_q.cls.nan;
    assign is_snan = stage_q.cls.snan;
    assign result  = stage_q.word;
    assign invalid = stage_q.invalid;

    // R8: a quieted word is still a NaN
    a_r8_quieted_is_nan: assert property (@(posedge clk) disable iff (rst)
        cls_c.snan |-> ((&q_word.expo) && (|q_word.frac)));

    // R8: quiet bit of the output matches the convention's quiet polarity
    a_r8_quiet_polarity: assert property (@(posedge clk) disable iff (rst)
        cls_c.snan |-> (q_word.frac[QBIT] == quiet_is_one));

    // R6: non-signalling operands are untouched by the quieter
    a_r6_passthrough: assert property (@(posedge clk) disable iff (rst)
        !cls_c.snan |-> (q_word == op_w && !inv_c));

    // R3: the flag from the quieter agrees with the classifier
    a_r3_flag_tracks_snan: assert property (@(posedge clk) disable iff (rst)
        inv_c == cls_c.snan);

    // R4/R5: sign and exponent never change
    a_r4_sign_exp_kept: assert property (@(posedge clk) disable iff (rst)
        (q_word.sign == op_w.sign) && (q_word.expo == op_w.expo));
endmodule

// File: tb/nan_quiet_unit_tb.sv
module nan_quiet_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] op_in;
    logic        quiet_is_one;
    logic        is_nan, is_snan, invalid;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    nan_quiet_unit u_dut (
        .clk(clk), .rst(rst), .op_in(op_in), .quiet_is_one(quiet_is_one),
        .is_nan(is_nan), .is_snan(is_snan), .result(result), .invalid(invalid)
    );

    typedef struct packed {
        logic [31:0] op;
        logic        mode;
        logic        nan;
        logic        snan;
        logic [31:0] res;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{32'h7FC00000, 1'b1, 1'b1, 1'b0, 32'h7FC00000}, // quiet in 2008 (R6)
        '{32'h7FC00000, 1'b0, 1'b1, 1'b1, 32'h7FA00000}, // legacy fix-up (R5)
        '{32'h7F800001, 1'b1, 1'b1, 1'b1, 32'h7FC00001}, // R4
        '{32'h7F800001, 1'b0, 1'b1, 1'b0, 32'h7F800001}, // quiet in legacy
        '{32'h7F800000, 1'b1, 1'b0, 1'b0, 32'h7F800000}, // +inf (R1)
        '{32'hFF800000, 1'b0, 1'b0, 1'b0, 32'hFF800000}, // -inf (R1)
        '{32'hFFC00001, 1'b0, 1'b1, 1'b1, 32'hFF800001}, // legacy, no fix-up
        '{32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 32'hFFFFFFFF},
        '{32'hFFFFFFFF, 1'b0, 1'b1, 1'b1, 32'hFFBFFFFF},
        '{32'h3F800000, 1'b0, 1'b0, 1'b0, 32'h3F800000},
        '{32'h00000000, 1'b1, 1'b0, 1'b0, 32'h00000000},
        '{32'hFFBFFFFF, 1'b1, 1'b1, 1'b1, 32'hFFFFFFFF},
        '{32'h7FE00000, 1'b0, 1'b1, 1'b1, 32'h7FA00000},
        '{32'h00400000, 1'b1, 1'b0, 1'b0, 32'h00400000}, // subnormal, bit 22 set
        '{32'h7F7FFFFF, 1'b0, 1'b0, 1'b0, 32'h7F7FFFFF}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] op, input logic mode);
        @(negedge clk);
        op_in = op;
        quiet_is_one = mode;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 5000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        string rq;
        rst = 1'b1;
        op_in = 32'h7F800001;
        quiet_is_one = 1'b1;
        repeat (3) @(negedge clk);
        // R7: reset clears outputs even with a signalling NaN on the input
        chk("R7", "reset result", result, 32'h0);
        chk("R7", "reset flags", {29'h0, is_nan, is_snan, invalid}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].mode);
            chk("R1", "is_nan", {31'h0, is_nan}, {31'h0, VECS[i].nan});
            chk("R2", "is_snan", {31'h0, is_snan}, {31'h0, VECS[i].snan});
            chk("R3", "invalid", {31'h0, invalid}, {31'h0, VECS[i].snan});
            if (VECS[i].snan && VECS[i].mode) rq = "R4";
            else if (VECS[i].snan)            rq = "R5";
            else                              rq = "R6";
            chk(rq, "result", result, VECS[i].res);
        end

        // R8: quieted results fed back read as quiet NaNs
        for (int m = 0; m < 2; m++) begin
            logic [31:0] q;
            apply(32'hFF800001 ^ {9'h0, (m == 0), 22'h0}, logic'(m));
            q = result;
            apply(q, logic'(m));
            chk("R8", "refeed is_nan", {31'h0, is_nan}, 32'h1);
            chk("R8", "refeed is_snan", {31'h0, is_snan}, 32'h0);
            chk("R8", "refeed invalid", {31'h0, invalid}, 32'h0);
            chk("R8", "refeed result", result, q);
        end

        // R7: one-edge latency; outputs hold until the next edge
        apply(32'h3F800000, 1'b1);
        @(negedge clk);
        op_in = 32'h7F800002;
        #1;
        chk("R7", "before edge result", result, 32'h3F800000);
        chk("R7", "before edge invalid", {31'h0, invalid}, 32'h0);
        @(negedge clk);
        chk("R7", "after edge result", result, 32'h7FC00002);
        chk("R7", "after edge invalid", {31'h0, invalid}, 32'h1);

        // R7: reset mid-run clears outputs
        rst = 1'b1;
        @(negedge clk);
        chk("R7", "mid reset result", result, 32'h0);
        rst = 1'b0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule